// File: doc/BRIEF.md
# Word Add/Subtract ALU with Overflow Trap

This block is the integer arithmetic and logic stage of a 64-bit datapath. It performs 32-bit word addition and subtraction, each in a trapping form and a wrapping form. It also performs four full-width bitwise operations. Each issued operation produces three values: a 64-bit result, a register write-enable, and an overflow-exception flag. All three come from output registers.

The trapping forms detect signed overflow on the 32-bit operation. When overflow occurs, the block raises the exception flag and withholds the write-enable, so the destination register keeps its old value. The wrapping forms compute modulo 2^32 and never raise the flag. Word results are widened to 64 bits by copying bit 31 into the upper half. The register file and the exception handler sit outside the block.

Top module: `addsub_trap_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_q` becomes 0 and `wr_en_q` and `ovf_trap_q` become 0.
- R2: Results appear one clock after issue. A cycle with `op_vld` low gives `wr_en_q` = 0 and `ovf_trap_q` = 0 in the next cycle, and `res_q` keeps its previous value.
- R3: Wrapping add (`op_sel` = 1) and wrapping subtract (`op_sel` = 3) compute `src_a[31:0] + src_b[31:0]` and `src_a[31:0] - src_b[31:0]` modulo 2^32, and never raise `ovf_trap_q`.
- R4: Every word add or subtract result (`op_sel` 0 to 3) has bits 63:32 equal to a copy of bit 31.
- R5: Trapping add (`op_sel` = 0) overflows when the two 32-bit operands have the same sign and the sign of the sum differs from theirs.
- R6: Trapping subtract (`op_sel` = 2) overflows when the two 32-bit operands differ in sign and the sign of the difference differs from the sign of `src_a`.
- R7: For an issued operation, `wr_en_q` is the inverse of `ovf_trap_q`. On a trap, `res_q` still carries the wrapped 32-bit value, sign-extended.
- R8: Word operations ignore `src_a[63:32]` and `src_b[63:32]`.
- R9: The bitwise operations work on all 64 bits: AND (`op_sel` = 4), OR (5), XOR (6) and NOR (7), where NOR gives the inverse of OR. They never trap and always write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | Issue an operation this cycle |
| op_sel | input | 3 | Operation code (see R3, R5, R6, R9) |
| src_a | input | 64 | First operand / minuend |
| src_b | input | 64 | Second operand / subtrahend |
| res_q | output | 64 | Registered result |
| wr_en_q | output | 1 | Registered destination write-enable |
| ovf_trap_q | output | 1 | Registered overflow-exception flag |

## Verification
Every result, write-enable and trap flag is due exactly one rising edge after the cycle in which the operation is issued. The bench drives each operation on a falling edge and then waits for the next falling edge. That half-period follows the single capturing edge, and the bench samples all three outputs there. The idle and reset checks use the same one-edge spacing, so no check ever reads a value that is still combinational.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Operation select encoding
  typedef enum logic [2:0] {
    OP_ADD_TRAP = 3'd0,
    OP_ADD_WRAP = 3'd1,
    OP_SUB_TRAP = 3'd2,
    OP_SUB_WRAP = 3'd3,
    OP_AND      = 3'd4,
    OP_OR       = 3'd5,
    OP_XOR      = 3'd6,
    OP_NOR      = 3'd7
  } alu_op_e;

  // Bitwise unit function select
  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2,
    BW_NOR = 2'd3
  } bw_fn_e;

endpackage

// File: rtl/alu_word_addsub.sv
module alu_word_addsub #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              is_sub,
  input  logic              trap_en,
  output logic [DATA_W-1:0] sum_ext,
  output logic              ovf
);
  localparam int EXT_W = DATA_W - WORD_W;
  localparam int MSB   = WORD_W - 1;

  logic [WORD_W-1:0] a_w;
  logic [WORD_W-1:0] b_w;
  logic [WORD_W-1:0] b_eff;
  logic [WORD_W-1:0] s_w;
  logic              raw_ovf;

  // Only the low word of each operand takes part
  assign a_w   = opa[WORD_W-1:0];
  assign b_w   = opb[WORD_W-1:0];
  assign b_eff = is_sub ? ~b_w : b_w;
  assign s_w   = a_w + b_eff + {{(WORD_W-1){1'b0}}, is_sub};

  // Signed overflow: effective addends share a sign that the sum lacks
  assign raw_ovf = (a_w[MSB] == b_eff[MSB]) && (s_w[MSB] != a_w[MSB]);
  assign ovf     = trap_en & raw_ovf;

  assign sum_ext = {{EXT_W{s_w[MSB]}}, s_w};
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  bw_fn_e            fn,
  output logic [DATA_W-1:0] y
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_comb begin
      unique case (fn)
        BW_AND:  y[i] = opa[i] & opb[i];
        BW_OR:   y[i] = opa[i] | opb[i];
        BW_XOR:  y[i] = opa[i] ^ opb[i];
        default: y[i] = ~(opa[i] | opb[i]);
      endcase
    end
  end
endmodule

// File: rtl/addsub_trap_alu.sv
module addsub_trap_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_vld,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] res_q,
  output logic              wr_en_q,
  output logic              ovf_trap_q
);
  localparam int EXT_W = DATA_W - WORD_W;

  logic              is_logic;
  logic              is_sub;
  logic              trap_en;
  logic [DATA_W-1:0] as_res;
  logic [DATA_W-1:0] bw_res;
  logic              as_ovf;
  logic              ovf_nxt;
  logic [DATA_W-1:0] res_nxt;
  bw_fn_e            bw_fn;

  // Decode: bit 2 picks the bitwise group, bit 1 subtract, bit 0 wrapping
  assign is_logic = op_sel[2];
  assign is_sub   = op_sel[1];
  assign trap_en  = ~op_sel[0] & ~op_sel[2];
  assign bw_fn    = bw_fn_e'(op_sel[1:0]);

  alu_word_addsub #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_addsub (
    .opa     (src_a),
    .opb     (src_b),
    .is_sub  (is_sub),
    .trap_en (trap_en),
    .sum_ext (as_res),
    .ovf     (as_ovf)
  );

  alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .opa (src_a),
    .opb (src_b),
    .fn  (bw_fn),
    .y   (bw_res)
  );

  assign res_nxt = is_logic ? bw_res : as_res;
  assign ovf_nxt = ~is_logic & as_ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q      <= '0;
      wr_en_q    <= 1'b0;
      ovf_trap_q <= 1'b0;
    end else begin
      wr_en_q    <= op_vld & ~ovf_nxt;
      ovf_trap_q <= op_vld & ovf_nxt;
      if (op_vld) res_q <= res_nxt;
    end
  end

  // R7: a trap never comes with a write
  a_r7_trap_blocks_write: assert property (@(posedge clk) disable iff (rst)
    ovf_trap_q |-> !wr_en_q);

  // R7: an issued operation gives exactly one of write or trap
  a_r7_write_or_trap: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> (wr_en_q ^ ovf_trap_q));

  // R2: idle cycles produce no write and no trap
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !op_vld |=> (!wr_en_q && !ovf_trap_q));

  // R2: idle cycles hold the result
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !op_vld |=> $stable(res_q));

  // R3: wrapping forms never trap
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (op_vld && !op_sel[2] && op_sel[0]) |=> !ovf_trap_q);

  // R4: word results are sign-extended from bit 31
  a_r4_sign_ext: assert property (@(posedge clk) disable iff (rst)
    (op_vld && !op_sel[2]) |=> (res_q[DATA_W-1:WORD_W] == {EXT_W{res_q[WORD_W-1]}}));

  // R9: bitwise forms always write
  a_r9_logic_writes: assert property (@(posedge clk) disable iff (rst)
    (op_vld && op_sel[2]) |=> (wr_en_q && !ovf_trap_q));

  // R9: NOR is the complement of OR over the full width
  a_r9_nor_full: assert property (@(posedge clk) disable iff (rst)
    (op_vld && op_sel == 3'd7) |=> (res_q == ~($past(src_a) | $past(src_b))));
endmodule

// File: tb/test_addsub_trap_alu.sv
module test_addsub_trap_alu;
  localparam int NV = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_vld = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [63:0] res_q;
  logic        wr_en_q;
  logic        ovf_trap_q;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  addsub_trap_alu i_addsub_trap_alu (
    .clk(clk), .rst(rst), .op_vld(op_vld), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b),
    .res_q(res_q), .wr_en_q(wr_en_q), .ovf_trap_q(ovf_trap_q)
  );

  localparam logic [2:0] T_OP [NV] = '{
    3'd0, 3'd1, 3'd2, 3'd3, 3'd0, 3'd0, 3'd2, 3'd0, 3'd1,
    3'd2, 3'd2, 3'd4, 3'd5, 3'd6, 3'd7, 3'd7, 3'd3
  };
  localparam logic [63:0] T_A [NV] = '{
    64'h0000_0000_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF,
    64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000,
    64'h0000_0000_0000_0005, 64'hDEAD_BEEF_0000_0003,
    64'h0000_0000_0000_0003, 64'h0000_0000_8000_0000,
    64'h0000_0000_FFFF_FFFF, 64'h0000_0000_7FFF_FFFF,
    64'h0000_0000_0000_0000, 64'hF0F0_F0F0_0F0F_0F0F,
    64'hF0F0_F0F0_0F0F_0F0F, 64'hF0F0_F0F0_0F0F_0F0F,
    64'hF0F0_F0F0_0F0F_0F0F, 64'h0000_0000_0000_0000,
    64'hAAAA_5555_0000_0000
  };
  localparam logic [63:0] T_B [NV] = '{
    64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001,
    64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001,
    64'h0000_0000_0000_0007, 64'h1234_5678_FFFF_FFFE,
    64'h0000_0000_0000_0005, 64'h0000_0000_8000_0000,
    64'h0000_0000_0000_0001, 64'h0000_0000_FFFF_FFFF,
    64'h0000_0000_8000_0000, 64'hFF00_FF00_FF00_FF00,
    64'hFF00_FF00_FF00_FF00, 64'hFF00_FF00_FF00_FF00,
    64'hFF00_FF00_FF00_FF00, 64'h0000_0000_0000_0000,
    64'h5555_AAAA_0000_0001
  };
  localparam logic [63:0] T_RES [NV] = '{
    64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_8000_0000,
    64'h0000_0000_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF,
    64'h0000_0000_0000_000C, 64'h0000_0000_0000_0001,
    64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0000,
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_8000_0000,
    64'hFFFF_FFFF_8000_0000, 64'hF000_F000_0F00_0F00,
    64'hFFF0_FFF0_FF0F_FF0F, 64'h0FF0_0FF0_F00F_F00F,
    64'h000F_000F_00F0_00F0, 64'hFFFF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF
  };
  localparam logic T_TRAP [NV] = '{
    1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
    1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0
  };
  localparam string T_TAG [NV] = '{
    "R5 max+1 trap", "R3 max+1 wrap", "R6 min-1 trap", "R3 min-1 wrap",
    "R5 plain add", "R8 upper ignored", "R4 negative diff", "R5 neg+neg trap",
    "R3 carry out wraps", "R6 pos-neg trap", "R6 zero-min trap",
    "R9 and", "R9 or", "R9 xor", "R9 nor", "R9 nor zero", "R8 wrap sub upper"
  };

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    op_vld = 1'b1; op_sel = op; src_a = a; src_b = b;
    @(negedge clk);
    op_vld = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cyc);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check64("R1 reset res", res_q, 64'h0);
    check1("R1 reset wr_en", wr_en_q, 1'b0);
    check1("R1 reset trap", ovf_trap_q, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      issue(T_OP[i], T_A[i], T_B[i]);
      check64(T_TAG[i], res_q, T_RES[i]);
      check1(T_TAG[i], ovf_trap_q, T_TRAP[i]);
      check1({T_TAG[i], " R7 write"}, wr_en_q, !T_TRAP[i]);
    end

    // R2: an idle cycle after a valid op gives no write or trap, result held
    issue(3'd0, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0020);
    check64("R2 before idle", res_q, 64'h30);
    @(negedge clk);
    check1("R2 idle wr_en", wr_en_q, 1'b0);
    check1("R2 idle trap", ovf_trap_q, 1'b0);
    check64("R2 idle hold", res_q, 64'h30);

    // R2: idle after a trap clears the flag
    issue(3'd0, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF);
    check1("R5 trap again", ovf_trap_q, 1'b1);
    @(negedge clk);
    check1("R2 trap cleared", ovf_trap_q, 1'b0);
    check64("R7 trap result held", res_q, 64'hFFFF_FFFF_FFFF_FFFE);

    // R1: reset during activity
    @(negedge clk);
    op_vld = 1'b1; op_sel = 3'd5; src_a = 64'hFFFF; src_b = 64'h1;
    rst = 1'b1;
    @(negedge clk);
    check64("R1 mid reset res", res_q, 64'h0);
    check1("R1 mid reset wr_en", wr_en_q, 1'b0);
    op_vld = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    finish_run();
  end
endmodule